// File: doc/BRIEF.md
# General-Purpose Pin Port with Falling-Edge Capture

This block is a bus-slave peripheral that gives software control over a small, parameterised set of general-purpose pins. A simple synchronous register bus reaches four 32-bit words, selected by a two-bit word index. Software drives output levels through one word and sets each pin's drive enable through another. It reads back the synchronised pin levels, and it collects falling transitions in a sticky per-pin capture word.

Each pin input passes through a two-flop synchroniser. A falling transition on the synchronised level sets that pin's capture bit. The bit then holds until software writes a 1 to it. A mask word selects which captured pins raise the single interrupt output. Reads return their data one clock after the request and change no state. The pin count can go as low as two or three.

Top module: `gp_port`

## Requirements
- R1: While reset is applied and after it is released, `pin_out`, `pin_oe`, `irq` and `bus_rdata` are 0, and all four words read as 0.
- R2: A write to word index 0 loads `bus_wdata[NPINS-1:0]` into the output levels on `pin_out` from the next clock. Writes to any other word leave `pin_out` unchanged.
- R3: A write to word index 1 loads the per-pin drive enables. A 1 bit asserts that pin's `pin_oe`. Writes to other words leave `pin_oe` unchanged.
- R4: A read of word index 0 returns the pin inputs after a two-flop synchroniser. The value seen in the read's clock is the one `pin_in` held two rising edges earlier, zero-extended to 32 bits.
- R5: When a pin's synchronised level goes from 1 to 0, its bit in word index 3 (capture) becomes 1. The bit stays 1 until it is cleared.
- R6: A write to word index 3 clears each capture bit whose write-data bit is 1 and leaves bits written with 0 unchanged. If a falling edge is detected in the same clock as its clear, the bit stays set.
- R7: `irq` is 1 exactly when some pin has both its capture bit and its mask bit set. The mask is word index 2 and resets to 0.
- R8: Bits at positions NPINS and above read as 0 in every word, and writes to them have no effect.
- R9: `bus_rdata` updates one clock after a cycle with `bus_re` high and holds otherwise. A read leaves the capture bits unchanged.
- R10: A rising transition on a pin does not set its capture bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Word index: 0 data, 1 direction, 2 mask, 3 capture |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one clock after the strobe |
| pin_in | input | NPINS | Raw pin input levels |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | 1 | Masked capture interrupt |

## Verification
The in-RTL assertions check four things on every clock. The output and direction words change only on their own writes. A capture bit rises only on a detected falling edge and drops only under a 1 in a capture write. `irq` never rises with an empty mask, and read data holds between reads. The bench scenarios are needed for the rest. They show the two-edge synchroniser latency on reads, the edge-wins result when a clear lands on the detection clock, and zeros above the pin count. A behavioural model with a sample-history queue is compared against every output on every clock.

// File: rtl/gp_port_pkg.sv
package gp_port_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LEVEL = 2'd0,
    SEL_DRIVE = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_CAPT  = 2'd3
  } word_sel_e;
endpackage

// File: rtl/gp_rst_sync.sv
module gp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic meta_q, hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_o = hold_q;
endmodule

// File: rtl/gp_in_sync.sv
module gp_in_sync #(
  parameter int unsigned NPINS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] raw_i,
  output logic [NPINS-1:0] level_o
);
  for (genvar b = 0; b < NPINS; b++) begin : g_bit
    logic stage1_q, stage2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q <= 1'b0;
        stage2_q <= 1'b0;
      end else begin
        stage1_q <= raw_i[b];
        stage2_q <= stage1_q;
      end
    end
    assign level_o[b] = stage2_q;
  end
endmodule

// File: rtl/gp_fall_cap.sv
module gp_fall_cap #(
  parameter int unsigned NPINS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] level_i,
  input  logic             clr_en_i,
  input  logic [NPINS-1:0] clr_mask_i,
  output logic [NPINS-1:0] cap_o
);
  logic [NPINS-1:0] last_q;
  logic [NPINS-1:0] fall;
  logic [NPINS-1:0] cap_q, cap_d;
  logic [NPINS-1:0] clr_bits;

  assign fall     = last_q & ~level_i;
  assign clr_bits = clr_en_i ? clr_mask_i : '0;

  // a detected edge outranks a clear in the same clock
  always_comb begin
    cap_d = (cap_q & ~clr_bits) | fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      cap_q  <= '0;
    end else begin
      last_q <= level_i;
      cap_q  <= cap_d;
    end
  end

  assign cap_o = cap_q;

  // R5: without a clear, no set bit may drop
  a_r5_cap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en_i |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

  // R6: a bit may only drop when a 1 was written to it
  a_r6_clear_needs_one: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~cap_q & $past(cap_q) & ~$past(clr_bits)) == '0));

  // R10: a bit may only rise on a falling edge
  a_r10_set_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cap_q & ~$past(cap_q) & ~$past(fall)) == '0));
endmodule

// File: rtl/gp_port.sv
module gp_port
  import gp_port_pkg::*;
#(
  parameter int unsigned NPINS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_re,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  logic             rst_ni;
  word_sel_e        sel;
  logic             wr_level, wr_drive, wr_mask, wr_capt;
  logic [NPINS-1:0] level_s;
  logic [NPINS-1:0] capt;
  logic [NPINS-1:0] out_q, out_d;
  logic [NPINS-1:0] oe_q, oe_d;
  logic [NPINS-1:0] mask_q, mask_d;
  logic [NPINS-1:0] rd_bits;
  logic [BUS_W-1:0] rdata_q, rdata_d;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  gp_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_ni)
  );

  gp_in_sync #(.NPINS(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_ni),
    .raw_i   (pin_in),
    .level_o (level_s)
  );

  assign sel      = word_sel_e'(bus_addr);
  assign wr_level = bus_we && (sel == SEL_LEVEL);
  assign wr_drive = bus_we && (sel == SEL_DRIVE);
  assign wr_mask  = bus_we && (sel == SEL_MASK);
  assign wr_capt  = bus_we && (sel == SEL_CAPT);

  gp_fall_cap #(.NPINS(NPINS)) u_cap (
    .clk        (clk),
    .rst_n      (rst_ni),
    .level_i    (level_s),
    .clr_en_i   (wr_capt),
    .clr_mask_i (bus_wdata[NPINS-1:0]),
    .cap_o      (capt)
  );

  // next-state logic
  always_comb begin
    out_d  = bus_wdata[NPINS-1:0];
    oe_d   = bus_wdata[NPINS-1:0];
    mask_d = bus_wdata[NPINS-1:0];
    unique case (sel)
      SEL_LEVEL: rd_bits = level_s;
      SEL_DRIVE: rd_bits = oe_q;
      SEL_MASK:  rd_bits = mask_q;
      SEL_CAPT:  rd_bits = capt;
      default:   rd_bits = '0;
    endcase
    rdata_d = BUS_W'(rd_bits);
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      oe_q    <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_level) out_q   <= out_d;
      if (wr_drive) oe_q    <= oe_d;
      if (wr_mask)  mask_q  <= mask_d;
      if (bus_re)   rdata_q <= rdata_d;
    end
  end

  assign pin_out   = out_q;
  assign pin_oe    = oe_q;
  assign bus_rdata = rdata_q;
  assign irq       = |(capt & mask_q);

  // R2: output levels move only on a level-word write
  a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_level |=> $stable(pin_out));

  // R3: drive enables move only on a direction-word write
  a_r3_oe_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_drive |=> $stable(pin_oe));

  // R7: an interrupt needs at least one enabled mask bit
  a_r7_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> (mask_q != '0));

  // R9: read data holds between read strobes
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/gp_port_bench.sv
module gp_port_bench;
  localparam int NP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_re = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit model_on = 1'b0;

  always #2.5 clk = ~clk;

  gp_port #(.NPINS(NP)) u_gp_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: pin sample history queue, newest first
  logic [NP-1:0] hist[$];
  int m_out, m_oe, m_mask, m_cap, m_rdata;

  always @(posedge clk) begin
    if (!model_on) begin
      hist = '{0, 0, 0};
      m_out = 0; m_oe = 0; m_mask = 0; m_cap = 0; m_rdata = 0;
    end else begin
      int seen, older, edges, clr, lim;
      lim   = (1 << NP) - 1;
      seen  = int'(hist[1]);
      older = int'(hist[2]);
      edges = older & ~seen;
      if (bus_re) begin
        case (bus_addr)
          2'd0: m_rdata = seen;
          2'd1: m_rdata = m_oe;
          2'd2: m_rdata = m_mask;
          default: m_rdata = m_cap;
        endcase
      end
      clr = (bus_we && bus_addr == 2'd3) ? (int'(bus_wdata) & lim) : 0;
      if (bus_we && bus_addr == 2'd0) m_out  = int'(bus_wdata) & lim;
      if (bus_we && bus_addr == 2'd1) m_oe   = int'(bus_wdata) & lim;
      if (bus_we && bus_addr == 2'd2) m_mask = int'(bus_wdata) & lim;
      m_cap = (m_cap & ~clr) | edges;
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (model_on) begin
      check(int'(pin_out) == m_out, "R2 pin_out model", 32'(pin_out), 32'(m_out));
      check(int'(pin_oe) == m_oe, "R3 pin_oe model", 32'(pin_oe), 32'(m_oe));
      check(irq == ((m_cap & m_mask) != 0), "R7 irq model", 32'(irq), 32'((m_cap & m_mask) != 0));
      check(bus_rdata == 32'(m_rdata), "R9 rdata model", bus_rdata, 32'(m_rdata));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    // R1: outputs quiet during reset
    check(pin_out == '0 && pin_oe == '0 && irq == 1'b0 && bus_rdata == '0,
          "R1 outputs in reset", {pin_out, pin_oe, irq}, 32'h0);
    rst_n = 1'b1;
    idle(4);
    model_on = 1'b1;
    idle(1);
    rd(2'd0, 32'h0, "R1 level word after reset");
    rd(2'd1, 32'h0, "R1 direction word after reset");
    rd(2'd2, 32'h0, "R1 mask word after reset");
    rd(2'd3, 32'h0, "R1 capture word after reset");

    // R2 / R8: output levels, upper bits ignored
    wr(2'd0, 32'hFFFF_FFF5);
    check(pin_out == 3'b101, "R2 pin_out after write", 32'(pin_out), 32'h5);
    // R3 / R8
    wr(2'd1, 32'hFFFF_FFFA);
    check(pin_oe == 3'b010, "R3 pin_oe after write", 32'(pin_oe), 32'h2);
    check(pin_out == 3'b101, "R2 pin_out untouched by direction write", 32'(pin_out), 32'h5);
    rd(2'd1, 32'h2, "R8 direction readback upper bits zero");
    wr(2'd0, 32'h1);
    check(pin_out == 3'b001 && pin_oe == 3'b010, "R2 independent output bits", {pin_out, pin_oe}, 32'h0A);

    // R4: synchronised input readback
    pin_in = 3'b111;
    idle(4);
    rd(2'd0, 32'h7, "R4 level readback");
    // R5: bit1 falls
    pin_in = 3'b101;
    idle(5);
    rd(2'd3, 32'h2, "R5 capture set by fall");
    rd(2'd3, 32'h2, "R9 read leaves capture intact");
    // R10: rise does not capture
    pin_in = 3'b111;
    idle(5);
    rd(2'd3, 32'h2, "R10 rise not captured");

    // R7: mask gating
    check(irq == 1'b0, "R7 irq off with empty mask", 32'(irq), 32'h0);
    wr(2'd2, 32'hFFFF_FFF2);
    check(irq == 1'b1, "R7 irq with mask", 32'(irq), 32'h1);
    rd(2'd2, 32'h2, "R8 mask readback upper bits zero");
    // R6: write 0 / other bit leaves bit1
    wr(2'd3, 32'h0000_0005);
    rd(2'd3, 32'h2, "R6 zero bits leave capture");
    wr(2'd3, 32'h0000_0002);
    rd(2'd3, 32'h0, "R6 one clears capture");
    check(irq == 1'b0, "R7 irq drops after clear", 32'(irq), 32'h0);

    // R6: clear landing on the detection clock; bit0 falls
    @(negedge clk);
    pin_in = 3'b110;
    bus_addr = 2'd3; bus_we = 1'b1; bus_wdata = 32'h1;
    idle(3);
    bus_we = 1'b0; bus_wdata = '0;
    idle(3);
    rd(2'd3, 32'h1, "R6 edge wins over same-clock clear");

    // R5: several pins fall together, R4 readback
    pin_in = 3'b000;
    idle(5);
    rd(2'd3, 32'h7, "R5 multiple captures");
    rd(2'd0, 32'h0, "R4 level readback low");
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R6 clear all");
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule